// File: doc/BRIEF.md
# DRAM Self Refresh Entry and Exit Sequencer

This block takes a DRAM from normal operation, where a periodic scheduler spreads CAS-before-RAS (CBR) refresh cycles over time, into low-power self refresh and back again. A power-management agent raises `sr_req`. The block takes the RAS, CAS and write-enable pins and enters self refresh with a CBR-style sequence. It acknowledges with `sr_ack` once RAS is low. When `sr_req` drops, it brings the device back out.

The refresh chain must not break across the low-power period. At entry, the RAS fall that starts self refresh must come within one refresh window of the RAS fall of the previous CBR cycle. When that previous refresh is too old, or when no refresh has happened since reset, the block first runs a CBR cycle of its own. The block tracks how long RAS has been low and never ends self refresh before the device minimum, even when the request is withdrawn early.

At exit, the block holds the pins high for the precharge time and then hands them back. It raises `refresh_now` so that the scheduler runs a CBR cycle at once. If that cycle does not start within the window measured from the RAS rise, a sticky error flag is set. All times are parameters counted in clock cycles.

Top module: `sref_sequencer`

## Requirements
- R1: After reset, `ras_n`, `cas_n` and `we_n` are high, and `sr_ack`, `refresh_now`, `pin_own` and `win_err` are low. `sr_state` is 0, which encodes the normal state. The other state codes are: own refresh 1, entry 2, self refresh 3, exit precharge 4, post-exit refresh 5.
- R2: Suppose `sr_req` is seen in the normal state when the age is at least T_WIN−T_CSR cycles. The age is the number of cycles since the last CBR RAS fall, and it counts as saturated after reset. The block then first runs its own CBR cycle and only then enters. In that cycle CAS falls first, RAS falls T_CSR cycles later and stays low for T_CBR cycles, and then both pins are high for T_CBRP cycles.
- R3: Entry drives CAS low for T_CSR cycles while RAS is still high, and then drives RAS low. `sr_ack` rises in the same cycle as that RAS fall. Every RAS fall the block drives happens while CAS is already low.
- R4: Suppose `sr_req` is seen in the normal state when the age is below T_WIN−T_CSR cycles. Entry then starts in the next cycle, with no extra refresh cycle.
- R5: RAS stays low for at least T_RASS cycles in self refresh. This holds even when `sr_req` is released earlier, including during entry. Exit starts in the cycle after the minimum is reached with `sr_req` low.
- R6: At exit, RAS and CAS rise together and `sr_ack` falls in that same cycle. The block keeps driving the pins high, with `pin_own` high, for T_RPS cycles.
- R7: After the precharge, `pin_own` drops and `refresh_now` rises. An `ext_cbr_start` pulse clears `refresh_now` and returns the block to the normal state.
- R8: If no `ext_cbr_start` arrives within T_WIN cycles of the exit RAS rise, the block sets `win_err`, drops `refresh_now` in the same cycle and returns to the normal state.
- R9: `win_err` stays set until reset. `ext_cbr_start` during self refresh, and `sr_req` after exit before the normal state is reached, cause no pin activity.
- R10: `we_n` is high at all times.
- R11: An `ext_cbr_start` pulse seen in the normal state or in the post-exit state resets the age to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Request for self refresh; release requests exit |
| ext_cbr_start | input | 1 | One-cycle pulse when the scheduler drops RAS in a CBR cycle |
| sr_ack | output | 1 | High while the device is held in self refresh |
| pin_own | output | 1 | High while this block drives the DRAM control pins |
| refresh_now | output | 1 | Asks the scheduler for an immediate CBR cycle after exit |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| sr_state | output | 3 | Current state code |
| win_err | output | 1 | Sticky flag: post-exit refresh missed its window |

## Verification
The bench builds the block with T_WIN=200, T_RASS=60, T_RPS=4, T_CSR=2, T_CBR=5 and T_CBRP=3. With these values the 125 µs window and the 100 µs minimum shrink to a few hundred cycles. This brings the skip-or-refresh decision within reach at both sides of its threshold (age 197 and 198). It also makes an early release during entry, a release after the minimum, and a missed post-exit window all cheap to reach. Each pin and handshake edge is predicted to the exact cycle and matched against the observed edges in order.

// File: rtl/sref_pkg.sv
package sref_pkg;
  typedef enum logic [2:0] {
    ST_NORM  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ENTER = 3'd2,
    ST_SELF  = 3'd3,
    ST_EXIT  = 3'd4,
    ST_POST  = 3'd5
  } sr_state_e;
endpackage

// File: rtl/sref_ctr.sv
// Saturating up-counter with synchronous clear.
module sref_ctr #(
  parameter int W        = 8,
  parameter int MAX      = 255,
  parameter bit RST_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = W'(MAX);
  localparam logic [W-1:0] RSTV = RST_FULL ? MAXV : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RSTV;
    end else if (clr) begin
      cnt <= '0;
    end else if (en && (cnt != MAXV)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sref_fsm.sv
// Next-state logic for the self refresh sequencer.
module sref_fsm
  import sref_pkg::*;
#(
  parameter int CW      = 8,
  parameter int AW      = 8,
  parameter int T_WIN   = 200,
  parameter int T_RASS  = 60,
  parameter int T_RPS   = 4,
  parameter int T_CSR   = 2,
  parameter int PRE_LEN = 10
) (
  input  sr_state_e         state_q,
  input  logic [CW-1:0]     tmr,
  input  logic [AW-1:0]     age,
  input  logic              sr_req,
  input  logic              ext_cbr_start,
  output sr_state_e         state_d,
  output logic              err_set
);
  localparam logic [AW-1:0] SKIP_LIM = AW'(T_WIN - T_CSR);
  localparam logic [CW-1:0] PRE_END  = CW'(PRE_LEN - 1);
  localparam logic [CW-1:0] ENT_END  = CW'(T_CSR - 1);
  localparam logic [CW-1:0] LOW_MIN  = CW'(T_RASS - 1);
  localparam logic [CW-1:0] RPS_END  = CW'(T_RPS - 1);
  localparam logic [CW-1:0] POST_END = CW'(T_WIN - T_RPS - 1);

  always_comb begin
    state_d = state_q;
    err_set = 1'b0;
    unique case (state_q)
      ST_NORM:  if (sr_req) state_d = (age < SKIP_LIM) ? ST_ENTER : ST_PRE;
      ST_PRE:   if (tmr == PRE_END) state_d = ST_ENTER;
      ST_ENTER: if (tmr == ENT_END) state_d = ST_SELF;
      ST_SELF:  if (!sr_req && (tmr >= LOW_MIN)) state_d = ST_EXIT;
      ST_EXIT:  if (tmr == RPS_END) state_d = ST_POST;
      ST_POST: begin
        if (ext_cbr_start) begin
          state_d = ST_NORM;
        end else if (tmr == POST_END) begin
          state_d = ST_NORM;
          err_set = 1'b1;
        end
      end
      default:  state_d = ST_NORM;
    endcase
  end
endmodule

// File: rtl/sref_pins.sv
// Decodes the DRAM control pins from the state and the in-state timer.
module sref_pins
  import sref_pkg::*;
#(
  parameter int CW    = 8,
  parameter int T_CSR = 2,
  parameter int T_CBR = 5
) (
  input  sr_state_e     state,
  input  logic [CW-1:0] tmr,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          pin_own,
  output logic          sr_ack,
  output logic          refresh_now
);
  localparam logic [CW-1:0] RAS_ON  = CW'(T_CSR);
  localparam logic [CW-1:0] RAS_OFF = CW'(T_CSR + T_CBR);

  assign we_n = 1'b1;

  always_comb begin
    ras_n       = 1'b1;
    cas_n       = 1'b1;
    pin_own     = 1'b0;
    sr_ack      = 1'b0;
    refresh_now = 1'b0;
    unique case (state)
      ST_PRE: begin
        pin_own = 1'b1;
        cas_n   = !(tmr < RAS_OFF);
        ras_n   = !((tmr >= RAS_ON) && (tmr < RAS_OFF));
      end
      ST_ENTER: begin
        pin_own = 1'b1;
        cas_n   = 1'b0;
      end
      ST_SELF: begin
        pin_own = 1'b1;
        cas_n   = 1'b0;
        ras_n   = 1'b0;
        sr_ack  = 1'b1;
      end
      ST_EXIT:  pin_own = 1'b1;
      ST_POST:  refresh_now = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/sref_sequencer.sv
// Self refresh entry/exit sequencer top level.
module sref_sequencer
  import sref_pkg::*;
#(
  parameter int T_WIN  = 12500,
  parameter int T_RASS = 10000,
  parameter int T_RPS  = 9,
  parameter int T_CSR  = 1,
  parameter int T_CBR  = 5,
  parameter int T_CBRP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_req,
  input  logic       ext_cbr_start,
  output logic       sr_ack,
  output logic       pin_own,
  output logic       refresh_now,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic [2:0] sr_state,
  output logic       win_err
);
  localparam int PRE_LEN = T_CSR + T_CBR + T_CBRP;
  localparam int CMAX0   = (T_WIN > T_RASS) ? T_WIN : T_RASS;
  localparam int CMAX    = (CMAX0 > PRE_LEN) ? CMAX0 : PRE_LEN;
  localparam int CW      = $clog2(CMAX + 1);
  localparam int AW      = $clog2(T_WIN + 1);

  sr_state_e     state_q, state_d;
  logic [CW-1:0] tmr;
  logic [AW-1:0] age;
  logic          err_set;
  logic          tmr_clr, age_clr;

  assign tmr_clr = (state_d != state_q);
  assign age_clr = (ext_cbr_start && ((state_q == ST_NORM) || (state_q == ST_POST)))
                 || ((state_q == ST_PRE) && (tmr == CW'(T_CSR)));

  sref_ctr #(.W(CW), .MAX(CMAX), .RST_FULL(1'b0)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(1'b1), .cnt(tmr)
  );

  sref_ctr #(.W(AW), .MAX(T_WIN), .RST_FULL(1'b1)) u_age (
    .clk(clk), .rst_n(rst_n), .clr(age_clr), .en(1'b1), .cnt(age)
  );

  sref_fsm #(
    .CW(CW), .AW(AW), .T_WIN(T_WIN), .T_RASS(T_RASS), .T_RPS(T_RPS),
    .T_CSR(T_CSR), .PRE_LEN(PRE_LEN)
  ) u_fsm (
    .state_q(state_q), .tmr(tmr), .age(age), .sr_req(sr_req),
    .ext_cbr_start(ext_cbr_start), .state_d(state_d), .err_set(err_set)
  );

  sref_pins #(.CW(CW), .T_CSR(T_CSR), .T_CBR(T_CBR)) u_pins (
    .state(state_q), .tmr(tmr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .pin_own(pin_own), .sr_ack(sr_ack), .refresh_now(refresh_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORM;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_err <= 1'b0;
    end else if (err_set) begin
      win_err <= 1'b1;
    end
  end

  assign sr_state = state_q;
endmodule

// File: rtl/sref_sequencer_chk.sv
// Temporal checks for the self refresh sequencer.
module sref_sequencer_chk #(
  parameter int T_RASS = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic sr_ack,
  input logic pin_own,
  input logic refresh_now,
  input logic win_err
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!ras_n) begin
      if (low_cnt < 32'(T_RASS)) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  // R3: the block never drops RAS unless CAS was already low
  a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_own && $fell(ras_n)) |-> (!cas_n && $past(!cas_n)));

  // R3: acknowledge only while both strobes are held low by the block
  a_r3_ack_pins: assert property (@(posedge clk) disable iff (!rst_n)
    sr_ack |-> (!ras_n && !cas_n && pin_own));

  // R5: self refresh ends only after the minimum low time
  a_r5_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_ack) |-> (low_cnt >= 32'(T_RASS)));

  // R6: exit lifts both strobes while the pins are still owned
  a_r6_exit_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_ack) |-> (ras_n && cas_n && pin_own));

  // R7: the refresh request is raised only after the pins are released
  a_r7_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_now |-> (!pin_own && !sr_ack));

  // R9: error flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    win_err |=> win_err);
endmodule

bind sref_sequencer sref_sequencer_chk #(.T_RASS(T_RASS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .sr_ack(sr_ack),
  .pin_own(pin_own), .refresh_now(refresh_now), .win_err(win_err)
);

// File: tb/sref_sequencer_test.sv
module sref_sequencer_test;
  localparam int T_WIN  = 200;
  localparam int T_RASS = 60;
  localparam int T_RPS  = 4;
  localparam int T_CSR  = 2;
  localparam int T_CBR  = 5;
  localparam int T_CBRP = 3;

  logic clk, rst_n, sr_req, ext_cbr_start;
  logic sr_ack, pin_own, refresh_now, ras_n, cas_n, we_n, win_err;
  logic [2:0] sr_state;

  sref_sequencer #(
    .T_WIN(T_WIN), .T_RASS(T_RASS), .T_RPS(T_RPS),
    .T_CSR(T_CSR), .T_CBR(T_CBR), .T_CBRP(T_CBRP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .ext_cbr_start(ext_cbr_start),
    .sr_ack(sr_ack), .pin_own(pin_own), .refresh_now(refresh_now),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .sr_state(sr_state),
    .win_err(win_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Edge kinds: index*2 + new value; index cas=0 ras=1 ack=2 ref=3 err=4
  typedef struct { int req; int kind; int at; } ev_t;
  ev_t exp_q[$];
  int  nchk = 0, nfail = 0;
  bit  mon_on = 1'b0, done = 1'b0, we_bad = 1'b0;
  logic [4:0] prv;

  task automatic push(input int req, input int kind, input int at);
    ev_t e;
    e.req = req; e.kind = kind; e.at = at;
    exp_q.push_back(e);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse_ext();
    ext_cbr_start = 1'b1;
    @(negedge clk);
    ext_cbr_start = 1'b0;
  endtask

  // Monitor: compares each observed edge with the head of the queue
  initial begin
    forever begin
      logic [4:0] s;
      @(negedge clk);
      s = {win_err, refresh_now, sr_ack, ras_n, cas_n};
      if (mon_on) begin
        if (!we_n) we_bad = 1'b1;
        for (int i = 0; i < 5; i++) begin
          if (s[i] != prv[i]) begin
            int k;
            k = i * 2 + int'(s[i]);
            nchk++;
            if (exp_q.size() == 0) begin
              nfail++;
              $display("FAIL R9: unexpected edge kind %0d at cycle %0d, expected none", k, cyc);
            end else begin
              ev_t e;
              e = exp_q.pop_front();
              if (e.kind != k || e.at != cyc) begin
                nfail++;
                $display("FAIL R%0d: actual edge %0d at cycle %0d, expected edge %0d at cycle %0d",
                         e.req, k, cyc, e.kind, e.at);
              end
            end
          end
        end
      end
      prv = s;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int c, d, e, p, g;
    rst_n = 1'b0; sr_req = 1'b0; ext_cbr_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ras_n", ras_n, 1); chk("R1 cas_n", cas_n, 1); chk("R1 we_n", we_n, 1);
    chk("R1 sr_ack", sr_ack, 0); chk("R1 refresh_now", refresh_now, 0);
    chk("R1 pin_own", pin_own, 0); chk("R1 win_err", win_err, 0);
    chk("R1 sr_state", sr_state, 0);
    mon_on = 1'b1;
    @(negedge clk);

    // Scenario A: no refresh since reset -> own CBR cycle first (R2), then entry (R3)
    c = cyc;
    sr_req = 1'b1;
    push(2, 0, c+1); push(2, 2, c+3); push(2, 1, c+8); push(2, 3, c+8);
    push(3, 0, c+11); push(3, 2, c+13); push(3, 5, c+13);
    push(5, 1, c+73); push(5, 3, c+73); push(6, 4, c+73); push(7, 7, c+77);
    wait_to(c+20);
    chk("R10 sr_state self", sr_state, 3);
    sr_req = 1'b0;                       // R5 early release
    wait_to(c+75);
    chk("R6 sr_state exit", sr_state, 4);
    chk("R6 pin_own exit", pin_own, 1);
    wait_to(c+85);
    push(7, 6, c+86);
    pulse_ext();
    chk("R7 sr_state normal", sr_state, 0);

    // Scenario C1: pulse in normal state, age 197 -> direct entry (R4, R11)
    d = cyc;
    pulse_ext();
    wait_to(d+198);
    e = cyc;
    sr_req = 1'b1;
    push(4, 0, e+1); push(4, 2, e+3); push(4, 5, e+3);
    push(5, 1, e+63); push(5, 3, e+63); push(5, 4, e+63); push(7, 7, e+67);
    @(negedge clk);
    sr_req = 1'b0;                       // R5 released during entry
    wait_to(e+70);
    p = cyc;
    push(7, 6, p+1);
    pulse_ext();                         // R11 pulse in post-exit state

    // Scenario C2: age 198 after post-exit pulse -> own refresh (R2, R11)
    wait_to(p+199);
    e = cyc;
    sr_req = 1'b1;
    push(2, 0, e+1); push(2, 2, e+3); push(2, 1, e+8); push(2, 3, e+8);
    push(11, 0, e+11); push(11, 2, e+13); push(11, 5, e+13);
    push(6, 1, e+101); push(6, 3, e+101); push(6, 4, e+101); push(7, 7, e+105);
    wait_to(e+100);
    sr_req = 1'b0;
    wait_to(e+110);
    push(7, 6, e+111);
    pulse_ext();

    // Scenario B: missed post-exit window -> sticky error (R8, R9)
    g = cyc;
    sr_req = 1'b1;
    push(4, 0, g+1); push(4, 2, g+3); push(4, 5, g+3);
    push(5, 1, g+101); push(5, 3, g+101); push(5, 4, g+101); push(8, 7, g+105);
    push(8, 6, g+301); push(8, 9, g+301);
    wait_to(g+50);
    pulse_ext();                         // R9 ignored during self refresh
    wait_to(g+100);
    sr_req = 1'b0;
    wait_to(g+150);
    sr_req = 1'b1;                       // R9 ignored in post-exit state
    wait_to(g+200);
    chk("R9 pins released", pin_own, 0);
    sr_req = 1'b0;
    wait_to(g+320);
    chk("R8 win_err", win_err, 1);
    chk("R8 sr_state", sr_state, 0);
    wait_to(g+340);
    chk("R9 win_err sticky", win_err, 1);
    chk("R10 we_n held high", int'(we_bad), 0);
    chk("R9 all expected edges seen", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule